// File: doc/BRIEF.md
# PCIe Root Port Error Message Router

This block sits inside a PCI Express root port and decides what happens to every error the port sees. Two kinds of error enter it. The first kind is conditions the port detects itself: eight uncorrectable and eight correctable strobe bits. The second kind is error messages received from devices below the port, which arrive as one strobe per class. Each error is placed in one of three classes. Fatal errors make the link unreliable. Non-fatal errors spoil one transaction but leave the link usable. Correctable errors have already been repaired by hardware. A per-bit severity register sorts each uncorrectable condition into fatal or non-fatal.

The block records unmasked local conditions and received messages in sticky status registers. Software clears these by writing one to a bit. A level interrupt is raised for each class while that class has status set and its interrupt enable is on. Upstream error message requests leave through a valid/ready stream. The port's own errors are reported when the device command enable for their class is set. A system-error enable also reports local fatal and non-fatal errors, and it alone decides whether received fatal and non-fatal messages are forwarded. Correctable traffic never depends on the system-error enable. Messages that arrive together are queued in one pending bit per class and leave one per cycle, highest severity first.

The message stream follows the usual rules. `msg_valid` and `msg_class` stay fixed until the cycle in which `msg_ready` is high. While the stream is stalled, new requests of a class that is already pending merge into that pending bit. No error is dropped, and none is duplicated inside a class. Configuration arrives through a write-only port that takes one register write per cycle.

Top module: `pcie_err_router`

## Requirements
- R1: After reset all status registers are zero, all three interrupts are low, `msg_valid` is low, and every enable, mask and severity register is zero.
- R2: An unmasked local condition or received message sets its status bit on the next clock edge. The bit stays set until software writes one to it. If a detection and a clear of the same bit happen in the same cycle, the bit stays set.
- R3: A local condition whose mask bit is one changes no status bit, raises no interrupt and produces no upstream message.
- R4: Severity bit i equal to 1 makes uncorrectable condition i fatal, and 0 makes it non-fatal.
- R5: Each interrupt is high exactly while its class has at least one status bit set and its enable is set in the interrupt enable register (bit 0 correctable, bit 1 non-fatal, bit 2 fatal). The fatal class counts uncorrectable status bits with severity 1 and the received-fatal bit. The non-fatal class counts uncorrectable status bits with severity 0 and the received-non-fatal bit. The correctable class counts correctable status bits and the received-correctable bit.
- R6: A local error of a class produces an upstream message when that class's bit is set in the device report enable register, which uses the same bit order as the interrupt enable register.
- R7: When the system-error enable (bit 0) is set, local fatal and non-fatal errors produce upstream messages even if their device report enables are clear. Local correctable errors are never reported because of this enable.
- R8: Received fatal and non-fatal messages are forwarded upstream only when the system-error enable is set. A received correctable message is forwarded only when the device report enable for the correctable class is set, whatever the system-error enable holds.
- R9: A request appears on `msg_valid` one cycle after its strobe. `msg_class` is 2 for fatal, 1 for non-fatal and 0 for correctable. Requests of several classes raised in the same cycle leave on consecutive accepted cycles in the order fatal, non-fatal, correctable.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and `msg_class` hold. Repeated requests of a class that is already pending produce only one message.
- R11: Register addresses for writes: 0 interrupt enable, 1 device report enable, 2 system-error enable, 3 uncorrectable mask, 4 correctable mask, 5 severity, 6 uncorrectable status (write one to clear), 7 correctable status (write one to clear), 8 received status (write one to clear; bit 0 correctable, bit 1 non-fatal, bit 2 fatal).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| unc_det | input | 8 | Uncorrectable condition strobes, one per condition |
| cor_det | input | 8 | Correctable condition strobes, one per condition |
| rx_fatal | input | 1 | Fatal message received from downstream |
| rx_nonfatal | input | 1 | Non-fatal message received from downstream |
| rx_cor | input | 1 | Correctable message received from downstream |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| unc_status | output | 8 | Sticky uncorrectable status |
| cor_status | output | 8 | Sticky correctable status |
| rx_status | output | 3 | Sticky received-message status |
| irq_fatal | output | 1 | Fatal class interrupt (level) |
| irq_nonfatal | output | 1 | Non-fatal class interrupt (level) |
| irq_cor | output | 1 | Correctable class interrupt (level) |
| msg_valid | output | 1 | Upstream message request valid |
| msg_ready | input | 1 | Upstream accepts the message |
| msg_class | output | 2 | Class of the message request |

## Verification
The hardest case to reach is a stalled stream that receives a correctable message first and then a fatal message twice. In that case the output stage holds the lower class while the higher class waits behind it, and the second fatal request has to merge with the first. The stimulus holds `msg_ready` low and pulses the three strobes on separate cycles. It then checks that the held class has not moved, releases `msg_ready`, and lets the scoreboard require exactly one correctable and then one fatal message. The same-cycle ordering case is reached by firing fatal, non-fatal and correctable local conditions in one strobe. The case of a detection and a clear landing together is reached by driving the status clear write and the condition strobe on the same edge.

// File: rtl/err_router_pkg.sv
`timescale 1ns/1ps
package err_router_pkg;
  typedef enum logic [1:0] {
    CLS_COR      = 2'd0,
    CLS_NONFATAL = 2'd1,
    CLS_FATAL    = 2'd2
  } err_cls_e;

  // class bit index used by enable, pending and received-status vectors
  localparam int IDX_COR      = 0;
  localparam int IDX_NONFATAL = 1;
  localparam int IDX_FATAL    = 2;
  localparam int N_CLS        = 3;

  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_INT_EN   = 4'd0;
  localparam logic [ADDR_W-1:0] A_DEV_EN   = 4'd1;
  localparam logic [ADDR_W-1:0] A_SYSERR   = 4'd2;
  localparam logic [ADDR_W-1:0] A_UNC_MASK = 4'd3;
  localparam logic [ADDR_W-1:0] A_COR_MASK = 4'd4;
  localparam logic [ADDR_W-1:0] A_UNC_SEV  = 4'd5;
  localparam logic [ADDR_W-1:0] A_UNC_STAT = 4'd6;
  localparam logic [ADDR_W-1:0] A_COR_STAT = 4'd7;
  localparam logic [ADDR_W-1:0] A_RX_STAT  = 4'd8;
endpackage

// File: rtl/err_cfg_regs.sv
`timescale 1ns/1ps
module err_cfg_regs
  import err_router_pkg::*;
#(
  parameter int N_UNC  = 8,
  parameter int N_COR  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [N_CLS-1:0]  int_en,
  output logic [N_CLS-1:0]  dev_en,
  output logic              syserr_en,
  output logic [N_UNC-1:0]  unc_mask,
  output logic [N_COR-1:0]  cor_mask,
  output logic [N_UNC-1:0]  unc_sev
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_en    <= '0;
      dev_en    <= '0;
      syserr_en <= 1'b0;
      unc_mask  <= '0;
      cor_mask  <= '0;
      unc_sev   <= '0;
    end else if (we) begin
      case (addr)
        A_INT_EN:   int_en    <= wdata[N_CLS-1:0];
        A_DEV_EN:   dev_en    <= wdata[N_CLS-1:0];
        A_SYSERR:   syserr_en <= wdata[0];
        A_UNC_MASK: unc_mask  <= wdata[N_UNC-1:0];
        A_COR_MASK: cor_mask  <= wdata[N_COR-1:0];
        A_UNC_SEV:  unc_sev   <= wdata[N_UNC-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/err_status_log.sv
`timescale 1ns/1ps
module err_status_log
  import err_router_pkg::*;
#(
  parameter int                W    = 8,
  parameter logic [ADDR_W-1:0] ADDR = 4'd6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      det,
  input  logic [W-1:0]      mask,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      ev,
  output logic [W-1:0]      st
);
  logic [W-1:0] clr;

  assign ev  = det & ~mask;
  assign clr = (we && addr == ADDR) ? wdata : '0;

  // a new detection beats a clear of the same bit
  always_ff @(posedge clk) begin
    if (!rst_n) st <= '0;
    else        st <= (st & ~clr) | ev;
  end

  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st & ~$past(st) & ~$past(det & ~mask)) == '0));

  p_sticky_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((det & ~mask) != '0) |=> ((st & $past(det & ~mask)) == $past(det & ~mask)));
endmodule

// File: rtl/err_msg_arb.sv
`timescale 1ns/1ps
module err_msg_arb
  import err_router_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CLS-1:0] req,
  input  logic             msg_ready,
  output logic             msg_valid,
  output err_cls_e         msg_class
);
  logic [N_CLS-1:0] pend, pend_nx, grant;
  err_cls_e         pick;
  logic             slot_free;

  assign pend_nx   = pend | req;
  assign slot_free = !msg_valid || msg_ready;

  always_comb begin
    grant = '0;
    pick  = CLS_COR;
    if (pend_nx[IDX_FATAL]) begin
      grant[IDX_FATAL] = 1'b1;
      pick = CLS_FATAL;
    end else if (pend_nx[IDX_NONFATAL]) begin
      grant[IDX_NONFATAL] = 1'b1;
      pick = CLS_NONFATAL;
    end else if (pend_nx[IDX_COR]) begin
      grant[IDX_COR] = 1'b1;
      pick = CLS_COR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      msg_valid <= 1'b0;
      msg_class <= CLS_COR;
    end else if (slot_free) begin
      pend      <= pend_nx & ~grant;
      msg_valid <= |pend_nx;
      msg_class <= pick;
    end else begin
      pend      <= pend_nx;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_class)));

  p_fatal_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && pend[IDX_FATAL]) |=> (msg_class == CLS_FATAL));

  p_idle_after_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && pend == '0 && req == '0) |=> !msg_valid);
endmodule

// File: rtl/pcie_err_router.sv
`timescale 1ns/1ps
module pcie_err_router
  import err_router_pkg::*;
#(
  parameter int N_UNC  = 8,
  parameter int N_COR  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_UNC-1:0]  unc_det,
  input  logic [N_COR-1:0]  cor_det,
  input  logic              rx_fatal,
  input  logic              rx_nonfatal,
  input  logic              rx_cor,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [N_UNC-1:0]  unc_status,
  output logic [N_COR-1:0]  cor_status,
  output logic [N_CLS-1:0]  rx_status,
  output logic              irq_fatal,
  output logic              irq_nonfatal,
  output logic              irq_cor,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [1:0]        msg_class
);
  logic [N_CLS-1:0] int_en, dev_en, req, rx_det, rx_ev, lvl;
  logic             syserr_en;
  logic [N_UNC-1:0] unc_mask, unc_sev, unc_ev;
  logic [N_COR-1:0] cor_mask, cor_ev;
  logic             loc_f, loc_nf, loc_c;
  err_cls_e         cls;

  err_cfg_regs #(.N_UNC(N_UNC), .N_COR(N_COR), .DATA_W(DATA_W)) u_cfg (
    .clk, .rst_n, .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .int_en, .dev_en, .syserr_en, .unc_mask, .cor_mask, .unc_sev
  );

  err_status_log #(.W(N_UNC), .ADDR(A_UNC_STAT)) u_unc_log (
    .clk, .rst_n, .det(unc_det), .mask(unc_mask), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata[N_UNC-1:0]), .ev(unc_ev), .st(unc_status)
  );

  err_status_log #(.W(N_COR), .ADDR(A_COR_STAT)) u_cor_log (
    .clk, .rst_n, .det(cor_det), .mask(cor_mask), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata[N_COR-1:0]), .ev(cor_ev), .st(cor_status)
  );

  assign rx_det = {rx_fatal, rx_nonfatal, rx_cor};

  err_status_log #(.W(N_CLS), .ADDR(A_RX_STAT)) u_rx_log (
    .clk, .rst_n, .det(rx_det), .mask('0), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata[N_CLS-1:0]), .ev(rx_ev), .st(rx_status)
  );

  // classify unmasked local events of this cycle
  assign loc_f  = |(unc_ev & unc_sev);
  assign loc_nf = |(unc_ev & ~unc_sev);
  assign loc_c  = |cor_ev;

  // upstream requests: system-error enable never touches the correctable class
  assign req[IDX_FATAL]    = (loc_f  && (dev_en[IDX_FATAL] || syserr_en))
                           || (rx_ev[IDX_FATAL] && syserr_en);
  assign req[IDX_NONFATAL] = (loc_nf && (dev_en[IDX_NONFATAL] || syserr_en))
                           || (rx_ev[IDX_NONFATAL] && syserr_en);
  assign req[IDX_COR]      = (loc_c || rx_ev[IDX_COR]) && dev_en[IDX_COR];

  err_msg_arb u_arb (
    .clk, .rst_n, .req, .msg_ready, .msg_valid, .msg_class(cls)
  );
  assign msg_class = cls;

  // level interrupts from class status
  assign lvl[IDX_FATAL]    = (|(unc_status & unc_sev))  || rx_status[IDX_FATAL];
  assign lvl[IDX_NONFATAL] = (|(unc_status & ~unc_sev)) || rx_status[IDX_NONFATAL];
  assign lvl[IDX_COR]      = (|cor_status)              || rx_status[IDX_COR];

  assign irq_fatal    = lvl[IDX_FATAL]    && int_en[IDX_FATAL];
  assign irq_nonfatal = lvl[IDX_NONFATAL] && int_en[IDX_NONFATAL];
  assign irq_cor      = lvl[IDX_COR]      && int_en[IDX_COR];

  p_cor_no_syserr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid && (cor_det != '0 || rx_cor) && !dev_en[IDX_COR]
     && unc_det == '0 && !rx_fatal && !rx_nonfatal && u_arb.pend == '0) |=> !msg_valid);
endmodule

// File: tb/sim_pcie_err_router.sv
`timescale 1ns/1ps
module sim_pcie_err_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] unc_det = '0, cor_det = '0;
  logic       rx_fatal = 1'b0, rx_nonfatal = 1'b0, rx_cor = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] unc_status, cor_status;
  logic [2:0] rx_status;
  logic       irq_fatal, irq_nonfatal, irq_cor, msg_valid;
  logic       msg_ready = 1'b1;
  logic [1:0] msg_class;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [1:0] expq[$];

  always #10 clk = ~clk;

  pcie_err_router u0 (
    .clk, .rst_n, .unc_det, .cor_det, .rx_fatal, .rx_nonfatal, .rx_cor,
    .cfg_we, .cfg_addr, .cfg_wdata, .unc_status, .cor_status, .rx_status,
    .irq_fatal, .irq_nonfatal, .irq_cor, .msg_valid, .msg_ready, .msg_class
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] u, input logic [7:0] c,
                       input logic f, input logic nf, input logic rc);
    @(negedge clk);
    unc_det = u; cor_det = c; rx_fatal = f; rx_nonfatal = nf; rx_cor = rc;
    @(negedge clk);
    unc_det = '0; cor_det = '0; rx_fatal = 0; rx_nonfatal = 0; rx_cor = 0;
    #4;
  endtask

  task automatic drain(input string tag);
    repeat (6) @(negedge clk);
    #4;
    chk({tag, " queue empty"}, expq.size(), 0);
  endtask

  // monitor: pops expected classes on every handshake
  always begin
    @(negedge clk);
    #2;
    if (rst_n && msg_valid && msg_ready) begin
      n_chk++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R6/R7/R8 unexpected message actual=%0d expected=none", msg_class);
      end else begin
        logic [1:0] e;
        e = expq.pop_front();
        if (msg_class !== e) begin
          n_bad++;
          $display("FAIL R9 message class actual=%0d expected=%0d", msg_class, e);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #4;
    // R1 reset state
    chk("R1 unc_status", unc_status, 0);
    chk("R1 cor_status", cor_status, 0);
    chk("R1 rx_status", rx_status, 0);
    chk("R1 irqs", {irq_fatal, irq_nonfatal, irq_cor}, 0);
    chk("R1 msg_valid", msg_valid, 0);

    // R11 map: enables, severity 0x0F -> bits 0..3 fatal
    cfg_wr(4'd0, 8'h07);
    cfg_wr(4'd5, 8'h0F);

    // R2 / R4 / R5: nonfatal local condition, no report enable -> no message
    pulse(8'h20, 8'h00, 0, 0, 0);
    chk("R2 status set", unc_status, 8'h20);
    chk("R4 nonfatal irq", irq_nonfatal, 1);
    chk("R4 fatal irq idle", irq_fatal, 0);
    drain("R6 no report");
    cfg_wr(4'd6, 8'h20);
    #4;
    chk("R2 w1c", unc_status, 0);
    chk("R5 irq drops", irq_nonfatal, 0);

    // R3 masked conditions with reports enabled
    cfg_wr(4'd1, 8'h07);
    cfg_wr(4'd3, 8'h02);
    cfg_wr(4'd4, 8'h04);
    pulse(8'h02, 8'h04, 0, 0, 0);
    chk("R3 unc masked", unc_status, 0);
    chk("R3 cor masked", cor_status, 0);
    chk("R3 irqs", {irq_fatal, irq_nonfatal, irq_cor}, 0);
    drain("R3 no message");

    // R6 / R4 fatal local report
    expq.push_back(2'd2);
    pulse(8'h01, 8'h00, 0, 0, 0);
    chk("R4 fatal irq", irq_fatal, 1);
    drain("R6 fatal");

    // R9 same-cycle ordering
    expq.push_back(2'd2); expq.push_back(2'd1); expq.push_back(2'd0);
    pulse(8'h41, 8'h08, 0, 0, 0);
    drain("R9 ordering");
    cfg_wr(4'd6, 8'hFF);
    cfg_wr(4'd7, 8'hFF);
    #4;
    chk("R2 all cleared", {irq_fatal, irq_nonfatal, irq_cor}, 0);

    // R7 system-error enable with report enables off
    cfg_wr(4'd1, 8'h00);
    cfg_wr(4'd2, 8'h01);
    expq.push_back(2'd1);
    pulse(8'h80, 8'h00, 0, 0, 0);
    pulse(8'h00, 8'h01, 0, 0, 0);
    drain("R7 syserr");
    chk("R7 cor status still logged", cor_status, 8'h01);

    // R8 received messages
    cfg_wr(4'd2, 8'h00);
    pulse(8'h00, 8'h00, 1, 0, 0);
    chk("R8 rx status", rx_status, 3'b100);
    chk("R8 rx fatal irq", irq_fatal, 1);
    drain("R8 no forward");
    cfg_wr(4'd2, 8'h01);
    expq.push_back(2'd1);
    pulse(8'h00, 8'h00, 0, 1, 0);
    pulse(8'h00, 8'h00, 0, 0, 1);
    drain("R8 syserr forward");
    cfg_wr(4'd1, 8'h01);
    expq.push_back(2'd0);
    pulse(8'h00, 8'h00, 0, 0, 1);
    drain("R8 cor forward");

    // R10 back-pressure with merge
    @(negedge clk);
    msg_ready = 1'b0;
    expq.push_back(2'd0); expq.push_back(2'd2);
    pulse(8'h00, 8'h00, 0, 0, 1);
    pulse(8'h00, 8'h00, 1, 0, 0);
    pulse(8'h00, 8'h00, 1, 0, 0);
    repeat (3) @(negedge clk);
    #4;
    chk("R10 valid held", msg_valid, 1);
    chk("R10 class held", msg_class, 2'd0);
    @(negedge clk);
    msg_ready = 1'b1;
    drain("R10 merged");

    // R2 detection beats same-cycle clear
    expq.push_back(2'd0);
    @(negedge clk);
    cor_det = 8'h10; cfg_we = 1'b1; cfg_addr = 4'd7; cfg_wdata = 8'h10;
    @(negedge clk);
    cor_det = '0; cfg_we = 1'b0;
    #4;
    chk("R2 set wins", cor_status, 8'h11);
    drain("R2 msg");

    // R5 interrupt enables
    cfg_wr(4'd0, 8'h00);
    #4;
    chk("R5 cor irq off", irq_cor, 0);
    cfg_wr(4'd0, 8'h01);
    #4;
    chk("R5 cor irq on", irq_cor, 1);
    chk("R5 fatal irq gated", irq_fatal, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule